// File: doc/BRIEF.md
# Accumulator Memory-Reference Execution Unit

This block carries out the memory-reference instructions of a 16-bit accumulator machine that also keeps a one-bit link. An instruction arrives already decoded, as an operation code, an indirect flag and a short address field, with a one-cycle `issue` strobe. The unit reads and writes a synchronous word memory and updates its accumulator (AC), link (L) and program counter (PC). It then raises `done` for one clock together with the architectural cycle count that the instruction is charged. Instruction fetch is outside the block. The unit only captures the current PC as the instruction's own address and advances PC by one when it accepts an instruction.

The effective address combines the high bits of the instruction's own address (its block) with the address field. With the indirect flag set, the word at that address supplies the final address. The control is a state machine with six named states. IDLE accepts an instruction. PTR reads the pointer word and DEREF loads it as the final address. ADDR reads the operand. EXEC updates the registers and performs any memory write. FIN presents `done`. From IDLE, an accepted instruction goes to FIN if it is an immediate or reserved code, to PTR if it is indirect, to ADDR if it needs an operand, and to EXEC otherwise. PTR always goes to DEREF. DEREF goes to ADDR when an operand is needed and to EXEC otherwise. ADDR goes to EXEC, EXEC to FIN, and FIN back to IDLE.

Top module: `mra_unit`

## Requirements
- R1: After reset AC, L, PC and `dot` are zero, `ready` is 1, and `done`, `cycles`, `mem_rd` and `mem_wr` are 0.
- R2: `issue` is taken only while `ready` is 1 and is ignored otherwise. On acceptance `dot` takes the current PC and PC advances by one, wrapping modulo 2^ADDR_W.
- R3: Code 0 loads AC with the zero-extended address field. Code 1 loads AC with the 16-bit ones complement of that value. Both ignore the indirect flag, touch no memory and report 1 cycle.
- R4: The effective address is {dot[ADDR_W-1:FIELD_W], field}. When the indirect flag is set, the low ADDR_W bits of the word at that address become the final address. Memory codes 2 to 13 report 2 cycles when direct and 3 when indirect.
- R5: Code 3 writes AC to the final address. Code 4 writes AC there and loads AC with the word that was there.
- R6: Codes 7, 8 and 9 combine the memory word into AC by AND, OR and XOR. Code 10 loads AC from the word.
- R7: Code 11 adds the word to AC modulo 2^16. L is inverted when the 17-bit sum carries out and is otherwise unchanged.
- R8: Code 12 adds the 16-bit two's complement of the word to AC. L is inverted on a carry out of that sum, so a zero word never inverts it.
- R9: Code 5 writes the word plus one back to memory. When that new value is zero, PC advances by one more.
- R10: Code 13 advances PC by one more when AC equals the memory word, and changes nothing else.
- R11: Code 2 sets PC to the final address. Code 6 writes the already advanced PC, zero-extended, to the final address and then sets PC to that address plus one.
- R12: `done` is high for exactly one clock per accepted instruction and `cycles` is valid only then. `ready` returns on the following clock.
- R13: Reserved codes 14 and 15 change nothing except the PC advance. They report 1 cycle and access no memory.
- R14: `mem_rd` and `mem_wr` are never high together and are both low while `ready` is high. Codes 3, 4, 5 and 6 write exactly once and all other codes never write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue | input | 1 | Instruction strobe, taken when ready |
| op | input | 4 | Decoded operation code |
| ind | input | 1 | Indirect flag |
| field | input | FIELD_W | Address field of the instruction |
| ready | output | 1 | Unit idle and able to accept |
| mem_addr | output | ADDR_W | Memory address |
| mem_rd | output | 1 | Memory read enable, data valid on the next clock |
| mem_wr | output | 1 | Memory write enable |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data |
| acc | output | 16 | Accumulator |
| link | output | 1 | Link bit |
| pc | output | ADDR_W | Program counter |
| dot | output | ADDR_W | Address of the last accepted instruction |
| done | output | 1 | Completion pulse |
| cycles | output | 2 | Charged cycle count, valid with done |

## Verification
The assertions cover the handshake on every clock. They check that reads and writes never overlap, that `done` lasts one clock and is followed by `ready`, that an accepted strobe makes the unit busy, and that AC, L and PC hold still while the unit is idle. The arithmetic itself can only be shown by the bench's scenarios, which compare against a behavioural model. These scenarios cover link inversion rather than setting, borrow-style subtraction with a zero operand, and increment-skip on wrap to zero. They also cover compare-skip, the block-relative address, the pointer dereference for each kind of access, the PC wrap at the top of memory, and a strobe held during a busy instruction.

// File: rtl/mra_pkg.sv
package mra_pkg;

    typedef enum logic [3:0] {
        OP_LDI  = 4'd0,
        OP_LDC  = 4'd1,
        OP_JMP  = 4'd2,
        OP_STO  = 4'd3,
        OP_XCH  = 4'd4,
        OP_INC  = 4'd5,
        OP_CALL = 4'd6,
        OP_AND  = 4'd7,
        OP_IOR  = 4'd8,
        OP_XOR  = 4'd9,
        OP_LOD  = 4'd10,
        OP_ADD  = 4'd11,
        OP_SUB  = 4'd12,
        OP_CMP  = 4'd13,
        OP_RSV0 = 4'd14,
        OP_RSV1 = 4'd15
    } mra_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PTR,
        ST_DEREF,
        ST_ADDR,
        ST_EXEC,
        ST_FIN
    } mra_state_e;

    // Completes without any memory phase
    function automatic logic op_is_local(mra_op_e o);
        return (o == OP_LDI) || (o == OP_LDC) || (o == OP_RSV0) || (o == OP_RSV1);
    endfunction

    // Needs the operand word read before execution
    function automatic logic op_needs_operand(mra_op_e o);
        return (o == OP_XCH) || (o == OP_INC) || (o == OP_AND) || (o == OP_IOR) ||
               (o == OP_XOR) || (o == OP_LOD) || (o == OP_ADD) || (o == OP_SUB) ||
               (o == OP_CMP);
    endfunction

    // Writes memory in the execute phase
    function automatic logic op_writes_mem(mra_op_e o);
        return (o == OP_STO) || (o == OP_XCH) || (o == OP_INC) || (o == OP_CALL);
    endfunction

endpackage

// File: rtl/mra_ctrl.sv
module mra_ctrl
    import mra_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    issue,
    input  mra_op_e op_i,
    input  logic    ind_i,
    output mra_op_e op_q,
    output logic    accept,
    output logic    ptr_load,
    output logic    exec_en,
    output logic    rd_en,
    output logic    done,
    output logic    ready
);

    mra_state_e state_q;
    mra_state_e state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q <= OP_LDI;
        end else if (accept) begin
            op_q <= op_i;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (issue) begin
                    if (op_is_local(op_i)) begin
                        state_d = ST_FIN;
                    end else if (ind_i) begin
                        state_d = ST_PTR;
                    end else if (op_needs_operand(op_i)) begin
                        state_d = ST_ADDR;
                    end else begin
                        state_d = ST_EXEC;
                    end
                end
            end
            ST_PTR:   state_d = ST_DEREF;
            ST_DEREF: state_d = op_needs_operand(op_q) ? ST_ADDR : ST_EXEC;
            ST_ADDR:  state_d = ST_EXEC;
            ST_EXEC:  state_d = ST_FIN;
            ST_FIN:   state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        ready    = (state_q == ST_IDLE);
        accept   = ready && issue;
        rd_en    = (state_q == ST_PTR) || (state_q == ST_ADDR);
        ptr_load = (state_q == ST_DEREF);
        exec_en  = (state_q == ST_EXEC);
        done     = (state_q == ST_FIN);
    end

endmodule

// File: rtl/mra_alu.sv
module mra_alu
    import mra_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int ADDR_W = 10
) (
    input  mra_op_e           op,
    input  logic [WORD_W-1:0] acc,
    input  logic              link,
    input  logic [ADDR_W-1:0] pc,
    input  logic [WORD_W-1:0] opnd,
    output logic [WORD_W-1:0] acc_n,
    output logic              link_n,
    output logic [WORD_W-1:0] wdata,
    output logic              skip
);

    localparam logic [WORD_W-1:0] W_ONE = WORD_W'(1);

    logic [WORD_W-1:0] incd;
    logic [WORD_W-1:0] negd;
    logic [WORD_W:0]   sum_add;
    logic [WORD_W:0]   sum_sub;

    always_comb begin
        incd    = opnd + W_ONE;
        negd    = ~opnd + W_ONE;
        sum_add = {1'b0, acc} + {1'b0, opnd};
        sum_sub = {1'b0, acc} + {1'b0, negd};

        acc_n  = acc;
        link_n = link;
        wdata  = acc;
        skip   = 1'b0;
        unique case (op)
            OP_XCH:  acc_n = opnd;
            OP_INC: begin
                wdata = incd;
                skip  = (incd == '0);
            end
            OP_CALL: wdata = {{(WORD_W-ADDR_W){1'b0}}, pc};
            OP_AND:  acc_n = acc & opnd;
            OP_IOR:  acc_n = acc | opnd;
            OP_XOR:  acc_n = acc ^ opnd;
            OP_LOD:  acc_n = opnd;
            OP_ADD: begin
                acc_n  = sum_add[WORD_W-1:0];
                link_n = link ^ sum_add[WORD_W];
            end
            OP_SUB: begin
                acc_n  = sum_sub[WORD_W-1:0];
                link_n = link ^ sum_sub[WORD_W];
            end
            OP_CMP:  skip = (acc == opnd);
            default: ;
        endcase
    end

endmodule

// File: rtl/mra_unit.sv
module mra_unit
    import mra_pkg::*;
#(
    parameter int WORD_W  = 16,
    parameter int ADDR_W  = 10,
    parameter int FIELD_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               issue,
    input  logic [3:0]         op,
    input  logic               ind,
    input  logic [FIELD_W-1:0] field,
    output logic               ready,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic               mem_rd,
    output logic               mem_wr,
    output logic [WORD_W-1:0]  mem_wdata,
    input  logic [WORD_W-1:0]  mem_rdata,
    output logic [WORD_W-1:0]  acc,
    output logic               link,
    output logic [ADDR_W-1:0]  pc,
    output logic [ADDR_W-1:0]  dot,
    output logic               done,
    output logic [1:0]         cycles
);

    localparam int BLK_W = ADDR_W - FIELD_W;
    localparam logic [ADDR_W-1:0] PC_ONE = ADDR_W'(1);

    mra_op_e           op_in;
    mra_op_e           op_q;
    logic              accept;
    logic              ptr_load;
    logic              exec_en;
    logic              rd_en;
    logic [ADDR_W-1:0] ea_q;
    logic [1:0]        cyc_q;
    logic [WORD_W-1:0] acc_n;
    logic              link_n;
    logic [WORD_W-1:0] alu_wdata;
    logic              skip;
    logic [WORD_W-1:0] field_ext;

    assign op_in     = mra_op_e'(op);
    assign field_ext = {{(WORD_W-FIELD_W){1'b0}}, field};

    mra_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .issue    (issue),
        .op_i     (op_in),
        .ind_i    (ind),
        .op_q     (op_q),
        .accept   (accept),
        .ptr_load (ptr_load),
        .exec_en  (exec_en),
        .rd_en    (rd_en),
        .done     (done),
        .ready    (ready)
    );

    mra_alu #(
        .WORD_W (WORD_W),
        .ADDR_W (ADDR_W)
    ) u_alu (
        .op     (op_q),
        .acc    (acc),
        .link   (link),
        .pc     (pc),
        .opnd   (mem_rdata),
        .acc_n  (acc_n),
        .link_n (link_n),
        .wdata  (alu_wdata),
        .skip   (skip)
    );

    // Effective address: block of the instruction's own location plus field,
    // replaced by the pointer word when indirect.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ea_q  <= '0;
            cyc_q <= 2'd0;
        end else if (accept) begin
            ea_q <= {pc[ADDR_W-1 -: BLK_W], field};
            if (op_is_local(op_in)) begin
                cyc_q <= 2'd1;
            end else begin
                cyc_q <= ind ? 2'd3 : 2'd2;
            end
        end else if (ptr_load) begin
            ea_q <= mem_rdata[ADDR_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc  <= '0;
            link <= 1'b0;
            pc   <= '0;
            dot  <= '0;
        end else if (accept) begin
            dot <= pc;
            pc  <= pc + PC_ONE;
            if (op_in == OP_LDI) begin
                acc <= field_ext;
            end else if (op_in == OP_LDC) begin
                acc <= ~field_ext;
            end
        end else if (exec_en) begin
            acc  <= acc_n;
            link <= link_n;
            if (op_q == OP_JMP) begin
                pc <= ea_q;
            end else if (op_q == OP_CALL) begin
                pc <= ea_q + PC_ONE;
            end else if (skip) begin
                pc <= pc + PC_ONE;
            end
        end
    end

    assign mem_addr  = ea_q;
    assign mem_rd    = rd_en;
    assign mem_wr    = exec_en && op_writes_mem(op_q);
    assign mem_wdata = alu_wdata;
    assign cycles    = done ? cyc_q : 2'd0;

endmodule

// File: rtl/mra_unit_chk.sv
module mra_unit_chk #(
    parameter int WORD_W = 16,
    parameter int ADDR_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              issue,
    input logic              ready,
    input logic              done,
    input logic [1:0]        cycles,
    input logic              mem_rd,
    input logic              mem_wr,
    input logic [WORD_W-1:0] acc,
    input logic              link,
    input logic [ADDR_W-1:0] pc
);

    // R14
    rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    // R14
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (!mem_rd && !mem_wr));

    // R12
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R12
    done_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> ready);

    // R4
    cycles_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cycles != 2'd0));

    // R2
    busy_after_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && issue) |=> !ready);

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !issue) |=> ($stable(pc) && $stable(acc) && $stable(link)));

endmodule

bind mra_unit mra_unit_chk #(
    .WORD_W (WORD_W),
    .ADDR_W (ADDR_W)
) chk_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .issue  (issue),
    .ready  (ready),
    .done   (done),
    .cycles (cycles),
    .mem_rd (mem_rd),
    .mem_wr (mem_wr),
    .acc    (acc),
    .link   (link),
    .pc     (pc)
);

// File: tb/mra_unit_tb_top.sv
`timescale 1ns/1ps
module mra_unit_tb_top;

    localparam int AW    = 10;
    localparam int FW    = 8;
    localparam int DEPTH = 1 << AW;

    logic          clk;
    logic          rst_n;
    logic          issue;
    logic [3:0]    op;
    logic          ind;
    logic [FW-1:0] field;
    logic          ready;
    logic [AW-1:0] mem_addr;
    logic          mem_rd;
    logic          mem_wr;
    logic [15:0]   mem_wdata;
    logic [15:0]   mem_rdata;
    logic [15:0]   acc;
    logic          link;
    logic [AW-1:0] pc;
    logic [AW-1:0] dot;
    logic          done;
    logic [1:0]    cycles;

    mra_unit #(.WORD_W(16), .ADDR_W(AW), .FIELD_W(FW)) dut_i (
        .clk(clk), .rst_n(rst_n), .issue(issue), .op(op), .ind(ind), .field(field),
        .ready(ready), .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .acc(acc), .link(link),
        .pc(pc), .dot(dot), .done(done), .cycles(cycles)
    );

    // 125 MHz
    initial clk = 1'b0;
    always #4 clk = ~clk;

    logic [15:0] mem_b   [DEPTH];
    logic [15:0] ref_mem [DEPTH];
    int          wr_cnt;

    always @(posedge clk) begin
        if (mem_wr) begin
            mem_b[mem_addr] <= mem_wdata;
            wr_cnt <= wr_cnt + 1;
        end
        if (mem_rd) mem_rdata <= mem_b[mem_addr];
    end

    int checks = 0;
    int errors = 0;
    bit mon_on = 0;

    // reference state
    logic [15:0]   m_acc  = '0;
    logic          m_link = 1'b0;
    logic [AW-1:0] m_pc   = '0;
    logic [AW-1:0] m_dot  = '0;
    int            m_cyc;
    int            m_wr;

    task automatic chk(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Per-clock comparison of architectural state while idle
    always @(posedge clk) begin
        #2;
        if (mon_on && rst_n && ready) begin
            chk("R2", "idle acc", {16'h0, acc}, {16'h0, m_acc});
            chk("R2", "idle pc", {22'h0, pc}, {22'h0, m_pc});
            chk("R2", "idle link", {31'h0, link}, {31'h0, m_link});
        end
    end

    task automatic preset(input int a, input logic [15:0] v);
        mem_b[a]   = v;
        ref_mem[a] = v;
    endtask

    task automatic model(input int o, input logic i, input logic [FW-1:0] f);
        logic [AW-1:0] ea;
        logic [15:0]   m;
        logic [15:0]   neg;
        logic [16:0]   s;
        m_dot = m_pc;
        m_pc  = m_pc + 1'b1;
        ea    = {m_dot[AW-1:FW], f};
        m_wr  = 0;
        if (o <= 1 || o >= 14) begin
            m_cyc = 1;
            if (o == 0) m_acc = {8'h00, f};
            if (o == 1) m_acc = ~{8'h00, f};
        end else begin
            if (i) ea = ref_mem[ea][AW-1:0];
            m_cyc = i ? 3 : 2;
            m = ref_mem[ea];
            case (o)
                2:  m_pc = ea;
                3:  begin ref_mem[ea] = m_acc; m_wr = 1; end
                4:  begin ref_mem[ea] = m_acc; m_acc = m; m_wr = 1; end
                5:  begin m = m + 16'd1; ref_mem[ea] = m; m_wr = 1;
                          if (m == 16'd0) m_pc = m_pc + 1'b1; end
                6:  begin ref_mem[ea] = {6'b0, m_pc}; m_pc = ea + 1'b1; m_wr = 1; end
                7:  m_acc = m_acc & m;
                8:  m_acc = m_acc | m;
                9:  m_acc = m_acc ^ m;
                10: m_acc = m;
                11: begin s = {1'b0, m_acc} + {1'b0, m};
                          if (s[16]) m_link = ~m_link; m_acc = s[15:0]; end
                12: begin neg = ~m + 16'd1; s = {1'b0, m_acc} + {1'b0, neg};
                          if (s[16]) m_link = ~m_link; m_acc = s[15:0]; end
                13: if (m_acc == m) m_pc = m_pc + 1'b1;
                default: ;
            endcase
        end
    endtask

    // hold: extra cycles the strobe stays high while busy, with a different op
    task automatic do_op(input string req, input int o, input logic i,
                         input logic [FW-1:0] f, input int hold);
        int n;
        int mism;
        @(negedge clk);
        model(o, i, f);
        wr_cnt = 0;
        op = o[3:0]; ind = i; field = f; issue = 1'b1;
        @(negedge clk);
        if (hold > 0) begin
            op = 4'd0; field = 8'h99;
            for (int k = 0; k < hold; k++) @(negedge clk);
        end
        issue = 1'b0;
        n = 0;
        while (!done && n < 50) begin
            @(negedge clk);
            n++;
        end
        chk(req, "done seen", {31'h0, done}, 32'd1);
        chk(req, "acc", {16'h0, acc}, {16'h0, m_acc});
        chk(req, "link", {31'h0, link}, {31'h0, m_link});
        chk(req, "pc", {22'h0, pc}, {22'h0, m_pc});
        chk(req, "dot", {22'h0, dot}, {22'h0, m_dot});
        chk(req, "cycles", {30'h0, cycles}, m_cyc);
        chk(req, "write count", wr_cnt, m_wr);
        mism = 0;
        for (int a = 0; a < DEPTH; a++) if (mem_b[a] !== ref_mem[a]) mism++;
        chk(req, "memory image mismatches", mism, 0);
        @(negedge clk);
        chk("R12", "done after one clock", {31'h0, done}, 32'd0);
        chk("R12", "ready after done", {31'h0, ready}, 32'd1);
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        checks++;
        $display("FAIL R12 watchdog actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst_n = 1'b0; issue = 1'b0; op = '0; ind = 1'b0; field = '0;
        wr_cnt = 0; mem_rdata = '0;
        for (int a = 0; a < DEPTH; a++) preset(a, 16'h0000);
        preset('h010, 16'h0F0F);
        preset('h011, 16'h0001);
        preset('h012, 16'h0003);
        preset('h013, 16'hFFFE);
        preset('h014, 16'h3C3C);
        preset('h015, 16'h0007);
        preset('h016, 16'h8000);
        preset('h030, 16'h0240);
        preset('h240, 16'h1234);
        preset('h2A0, 16'h0150);
        preset('h131, 16'h03FF);
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1", "acc", {16'h0, acc}, 0);
        chk("R1", "link", {31'h0, link}, 0);
        chk("R1", "pc", {22'h0, pc}, 0);
        chk("R1", "dot", {22'h0, dot}, 0);
        chk("R1", "ready", {31'h0, ready}, 1);
        chk("R1", "done", {31'h0, done}, 0);
        chk("R1", "cycles", {30'h0, cycles}, 0);
        chk("R1", "mem strobes", {30'h0, mem_rd, mem_wr}, 0);
        rst_n = 1'b1;
        mon_on = 1;

        do_op("R3", 0, 1'b0, 8'h5A, 0);
        do_op("R3", 1, 1'b1, 8'h5A, 0);   // complement, indirect ignored
        do_op("R6", 7, 1'b0, 8'h10, 0);
        do_op("R6", 8, 1'b0, 8'h14, 0);
        do_op("R6", 9, 1'b0, 8'h10, 0);
        do_op("R6", 10, 1'b0, 8'h14, 0);
        do_op("R5", 3, 1'b0, 8'h20, 0);
        do_op("R3", 1, 1'b0, 8'h00, 0);
        do_op("R5", 4, 1'b0, 8'h10, 0);
        do_op("R4", 10, 1'b1, 8'h30, 0);   // indirect load
        do_op("R4", 3, 1'b1, 8'h30, 0);    // indirect store
        do_op("R3", 1, 1'b0, 8'h00, 0);
        do_op("R7", 11, 1'b0, 8'h11, 0);   // carry: link inverts to 1
        do_op("R7", 11, 1'b0, 8'h16, 0);   // no carry: link stays
        do_op("R7", 11, 1'b0, 8'h16, 0);   // carry again: link back to 0
        do_op("R3", 0, 1'b0, 8'h05, 0);
        do_op("R8", 12, 1'b0, 8'h12, 0);   // 5-3, carry out inverts link
        do_op("R8", 12, 1'b0, 8'h15, 0);   // 2-7, no carry
        do_op("R8", 12, 1'b0, 8'h21, 0);   // zero word, no inversion
        do_op("R9", 5, 1'b0, 8'h13, 0);    // to FFFF, no skip
        do_op("R9", 5, 1'b0, 8'h13, 0);    // wraps to zero, skip
        do_op("R6", 10, 1'b0, 8'h12, 0);
        do_op("R10", 13, 1'b0, 8'h12, 0);  // equal, skip
        do_op("R10", 13, 1'b0, 8'h11, 0);  // unequal
        do_op("R11", 6, 1'b0, 8'h60, 0);   // call direct
        do_op("R11", 2, 1'b1, 8'h30, 0);   // jump indirect to block 2
        do_op("R4", 10, 1'b0, 8'h40, 0);   // block-relative address
        do_op("R11", 6, 1'b1, 8'hA0, 0);   // call indirect
        do_op("R9", 5, 1'b1, 8'h13, 0);    // indirect increment, block 1
        do_op("R11", 2, 1'b1, 8'h31, 0);   // jump to last word
        do_op("R2", 0, 1'b0, 8'h77, 0);    // PC wraps to zero
        do_op("R13", 14, 1'b1, 8'h10, 0);
        do_op("R13", 15, 1'b0, 8'h00, 0);
        do_op("R2", 11, 1'b1, 8'h30, 2);   // strobe held while busy is ignored

        mon_on = 0;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule